// File: doc/BRIEF.md
# Two-Master Request-Grant Bus Multiplexer

This block lets two upstream bus masters share one downstream slave over a point-to-point link. The link has two channels. The address channel moves a request with a req/gnt handshake. The response channel moves a reply with an rvalid/rready handshake. A transfer on either channel completes on a rising clock edge where both of its handshake signals are high.

The multiplexer decides between the two masters by round-robin, and it makes that decision only while no request is being offered to the slave. It presents the winner's address-phase signals downstream. On the way down it widens the transaction identifier with one extra most-significant bit that holds the index of the originating master. The slave returns that identifier with its response. The multiplexer reads the extra bit to choose the master that receives the response, and it removes the bit before forwarding.

The slave is expected to answer in the order in which it accepted requests. A counter limits the number of accepted but unanswered transactions. A one-entry response stage keeps every slave-side output free of any combinational path from slave-side inputs. No output of one master port depends combinationally on the inputs of the other master port.

Top module: `reqgnt_mux2`

## Requirements
- R1: While rst_n is low, s_req, m0_rvalid, m1_rvalid, m0_gnt and m1_gnt are all 0.
- R2: A master request is seen in an idle cycle. From the next cycle, s_req is 1 and s_addr, s_we, s_be, s_wdata carry that master's values. s_aid is the master's aid with one bit added on top: 0 for master 0 and 1 for master 1.
- R3: While s_req is 1 and s_gnt is 0, s_req stays 1 and the selected master does not change in the next cycle.
- R4: When both masters request in an idle cycle, the master that did not win the previous decision is chosen. Master 0 has priority after reset.
- R5: No more than MAX_OUT (default 4) transactions are accepted by the slave and left unanswered at once. s_req is not raised while the limit is reached, and it rises again once a response is taken.
- R6: A response is routed by the top bit of s_rid (0 gives master 0, 1 gives master 1). The other master sees no rvalid. The forwarded rid holds the lower ID_W bits of s_rid. rdata and err pass through unchanged.
- R7: A response taken from the slave appears at its master in the next cycle. While that response waits for a master that is not ready, s_rready is 0. When the master takes it, s_rready stays 1 in consecutive cycles.
- R8: Once m0_rvalid or m1_rvalid is 1, it stays 1 with stable rid and rdata until that master's rready is 1 on an edge.
- R9: m0_gnt and m1_gnt are 1 only for the selected master, and only in cycles where s_req and s_gnt are both 1.
- R10: After each completed address transfer, s_req is 0 for at least one cycle.
- R11: While no transaction is outstanding, s_rready is 0. A response offered in that state reaches no master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| m0_req | input | 1 | Master 0 request |
| m0_gnt | output | 1 | Master 0 grant |
| m0_addr | input | 32 | Master 0 address |
| m0_we | input | 1 | Master 0 write enable |
| m0_be | input | 4 | Master 0 byte enables |
| m0_wdata | input | 32 | Master 0 write data |
| m0_aid | input | ID_W | Master 0 transaction identifier |
| m0_rvalid | output | 1 | Response valid to master 0 |
| m0_rready | input | 1 | Master 0 ready for a response |
| m0_rdata | output | 32 | Response data to master 0 |
| m0_err | output | 1 | Response error to master 0 |
| m0_rid | output | ID_W | Response identifier to master 0 |
| m1_req | input | 1 | Master 1 request |
| m1_gnt | output | 1 | Master 1 grant |
| m1_addr | input | 32 | Master 1 address |
| m1_we | input | 1 | Master 1 write enable |
| m1_be | input | 4 | Master 1 byte enables |
| m1_wdata | input | 32 | Master 1 write data |
| m1_aid | input | ID_W | Master 1 transaction identifier |
| m1_rvalid | output | 1 | Response valid to master 1 |
| m1_rready | input | 1 | Master 1 ready for a response |
| m1_rdata | output | 32 | Response data to master 1 |
| m1_err | output | 1 | Response error to master 1 |
| m1_rid | output | ID_W | Response identifier to master 1 |
| s_req | output | 1 | Request to the slave |
| s_gnt | input | 1 | Slave grant |
| s_addr | output | 32 | Address to the slave |
| s_we | output | 1 | Write enable to the slave |
| s_be | output | 4 | Byte enables to the slave |
| s_wdata | output | 32 | Write data to the slave |
| s_aid | output | ID_W+1 | Widened identifier to the slave |
| s_rvalid | input | 1 | Slave response valid |
| s_rready | output | 1 | Ready for a slave response |
| s_rdata | input | 32 | Slave response data |
| s_err | input | 1 | Slave response error |
| s_rid | input | ID_W+1 | Widened identifier returned by the slave |

## Verification
The first pattern is a lone request from master 1 against a slave that holds off its grant. It separates correct selection, ID widening and hold behaviour from a design that forwards the wrong master or drops the request early. The second pattern has both masters requesting back to back. It shows whether the decision alternates or sticks to one master, and whether the idle cycle after each grant is kept. The third pattern is a master that keeps requesting while the slave never answers. It exposes any off-by-one in the outstanding limit, and the responses that follow check routing, stalls in the response stage and full-rate draining. A response offered while nothing is outstanding confirms that replies cannot get ahead of their requests.

// File: rtl/mux2_pkg.sv
package mux2_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  typedef enum logic {
    PORT0 = 1'b0,
    PORT1 = 1'b1
  } port_e;
endpackage

// File: rtl/mux2_arbiter.sv
module mux2_arbiter
  import mux2_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req0,
  input  logic  req1,
  input  logic  room,
  input  logic  xfer,
  output logic  phase,
  output port_e sel,
  output logic  launch
);
  logic  phase_q;
  port_e sel_q;
  port_e prio_q;
  port_e pick;

  // Contended requests go to the priority holder; otherwise the lone requester.
  always_comb begin
    if (req0 && req1)  pick = prio_q;
    else if (req1)     pick = PORT1;
    else               pick = PORT0;
  end

  // A decision is taken only while nothing is offered downstream.
  assign launch = !phase_q && (req0 || req1) && room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      sel_q   <= PORT0;
      prio_q  <= PORT0;
    end else if (launch) begin
      phase_q <= 1'b1;
      sel_q   <= pick;
      prio_q  <= port_e'(~pick);
    end else if (xfer) begin
      phase_q <= 1'b0;
    end
  end

  assign phase = phase_q;
  assign sel   = sel_q;
endmodule

// File: rtl/mux2_txn_count.sv
module mux2_txn_count #(
  parameter int unsigned MAX_OUT = 4,
  parameter int unsigned CNT_W   = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             room,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c,
                                                input logic up, input logic dn);
    case ({up, dn})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_cnt(cnt_q, inc, dec);
  end

  assign cnt  = cnt_q;
  assign room = cnt_q < CNT_W'(MAX_OUT);
  assign busy = cnt_q != '0;
endmodule

// File: rtl/mux2_resp_stage.sv
module mux2_resp_stage
  import mux2_pkg::*;
#(
  parameter int unsigned ID_W   = 2,
  parameter int unsigned S_ID_W = ID_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              s_rvalid,
  input  logic [S_ID_W-1:0] s_rid,
  input  logic [DATA_W-1:0] s_rdata,
  input  logic              s_err,
  output logic              s_rready,
  input  logic              m0_rready,
  input  logic              m1_rready,
  output logic              m0_rvalid,
  output logic              m1_rvalid,
  output logic [ID_W-1:0]   out_rid,
  output logic [DATA_W-1:0] out_rdata,
  output logic              out_err,
  output logic              take
);
  logic              vld_q;
  port_e             dst_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] data_q;
  logic              err_q;
  logic              deq;

  function automatic port_e route_of(input logic [S_ID_W-1:0] rid);
    return port_e'(rid[S_ID_W-1]);
  endfunction

  function automatic logic [ID_W-1:0] strip_id(input logic [S_ID_W-1:0] rid);
    return rid[ID_W-1:0];
  endfunction

  assign deq      = vld_q && ((dst_q == PORT1) ? m1_rready : m0_rready);
  // Driven only from state and master-side inputs, never from slave-side inputs.
  assign s_rready = busy && (!vld_q || deq);
  assign take     = s_rvalid && s_rready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      dst_q  <= PORT0;
      id_q   <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (take) begin
      vld_q  <= 1'b1;
      dst_q  <= route_of(s_rid);
      id_q   <= strip_id(s_rid);
      data_q <= s_rdata;
      err_q  <= s_err;
    end else if (deq) begin
      vld_q  <= 1'b0;
    end
  end

  assign m0_rvalid = vld_q && (dst_q == PORT0);
  assign m1_rvalid = vld_q && (dst_q == PORT1);
  assign out_rid   = id_q;
  assign out_rdata = data_q;
  assign out_err   = err_q;
endmodule

// File: rtl/reqgnt_mux2.sv
module reqgnt_mux2
  import mux2_pkg::*;
#(
  parameter int unsigned ID_W    = 2,
  parameter int unsigned MAX_OUT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m0_req,
  output logic              m0_gnt,
  input  logic [ADDR_W-1:0] m0_addr,
  input  logic              m0_we,
  input  logic [BE_W-1:0]   m0_be,
  input  logic [DATA_W-1:0] m0_wdata,
  input  logic [ID_W-1:0]   m0_aid,
  output logic              m0_rvalid,
  input  logic              m0_rready,
  output logic [DATA_W-1:0] m0_rdata,
  output logic              m0_err,
  output logic [ID_W-1:0]   m0_rid,
  input  logic              m1_req,
  output logic              m1_gnt,
  input  logic [ADDR_W-1:0] m1_addr,
  input  logic              m1_we,
  input  logic [BE_W-1:0]   m1_be,
  input  logic [DATA_W-1:0] m1_wdata,
  input  logic [ID_W-1:0]   m1_aid,
  output logic              m1_rvalid,
  input  logic              m1_rready,
  output logic [DATA_W-1:0] m1_rdata,
  output logic              m1_err,
  output logic [ID_W-1:0]   m1_rid,
  output logic              s_req,
  input  logic              s_gnt,
  output logic [ADDR_W-1:0] s_addr,
  output logic              s_we,
  output logic [BE_W-1:0]   s_be,
  output logic [DATA_W-1:0] s_wdata,
  output logic [ID_W:0]     s_aid,
  input  logic              s_rvalid,
  output logic              s_rready,
  input  logic [DATA_W-1:0] s_rdata,
  input  logic              s_err,
  input  logic [ID_W:0]     s_rid
);
  localparam int unsigned S_ID_W = ID_W + 1;
  localparam int unsigned CNT_W  = $clog2(MAX_OUT + 1);

  function automatic logic [S_ID_W-1:0] extend_id(input port_e p, input logic [ID_W-1:0] id);
    return {logic'(p), id};
  endfunction

  // Named internal events, also observed by the bound checker.
  logic             phase;
  port_e            sel;
  logic             launch;
  logic             addr_xfer;
  logic             resp_take;
  logic             room;
  logic             busy;
  logic [CNT_W-1:0] out_cnt;
  logic [ID_W-1:0]  fwd_rid;
  logic [DATA_W-1:0] fwd_rdata;
  logic             fwd_err;

  mux2_arbiter u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req0   (m0_req),
    .req1   (m1_req),
    .room   (room),
    .xfer   (addr_xfer),
    .phase  (phase),
    .sel    (sel),
    .launch (launch)
  );

  mux2_txn_count #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (addr_xfer),
    .dec   (resp_take),
    .cnt   (out_cnt),
    .room  (room),
    .busy  (busy)
  );

  mux2_resp_stage #(.ID_W(ID_W), .S_ID_W(S_ID_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .s_rvalid  (s_rvalid),
    .s_rid     (s_rid),
    .s_rdata   (s_rdata),
    .s_err     (s_err),
    .s_rready  (s_rready),
    .m0_rready (m0_rready),
    .m1_rready (m1_rready),
    .m0_rvalid (m0_rvalid),
    .m1_rvalid (m1_rvalid),
    .out_rid   (fwd_rid),
    .out_rdata (fwd_rdata),
    .out_err   (fwd_err),
    .take      (resp_take)
  );

  // Address path: the registered selection steers the winner downstream.
  assign s_req     = phase;
  assign s_addr    = (sel == PORT1) ? m1_addr  : m0_addr;
  assign s_we      = (sel == PORT1) ? m1_we    : m0_we;
  assign s_be      = (sel == PORT1) ? m1_be    : m0_be;
  assign s_wdata   = (sel == PORT1) ? m1_wdata : m0_wdata;
  assign s_aid     = extend_id(sel, (sel == PORT1) ? m1_aid : m0_aid);
  assign addr_xfer = s_req && s_gnt;
  assign m0_gnt    = addr_xfer && (sel == PORT0);
  assign m1_gnt    = addr_xfer && (sel == PORT1);

  // Response path: both masters see the held payload, only one sees valid.
  assign m0_rdata = fwd_rdata;
  assign m1_rdata = fwd_rdata;
  assign m0_err   = fwd_err;
  assign m1_err   = fwd_err;
  assign m0_rid   = fwd_rid;
  assign m1_rid   = fwd_rid;
endmodule

// File: rtl/mux2_checker.sv
module mux2_checker #(
  parameter int unsigned ID_W    = 2,
  parameter int unsigned MAX_OUT = 4,
  parameter int unsigned CNT_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m0_req,
  input logic              m1_req,
  input logic              m0_gnt,
  input logic              m1_gnt,
  input logic              m0_rvalid,
  input logic              m1_rvalid,
  input logic              m0_rready,
  input logic              m1_rready,
  input logic [31:0]       m0_rdata,
  input logic [31:0]       m1_rdata,
  input logic [ID_W-1:0]   m0_rid,
  input logic [ID_W-1:0]   m1_rid,
  input logic              s_req,
  input logic              s_gnt,
  input logic [31:0]       s_addr,
  input logic [ID_W:0]     s_aid,
  input logic              s_rready,
  input logic              launch,
  input logic [CNT_W-1:0]  out_cnt
);
  logic seen_launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_launch <= 1'b0;
    else if (launch) seen_launch <= 1'b1;
  end

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!s_req && !m0_rvalid && !m1_rvalid && !m0_gnt && !m1_gnt);
    end
  end

  assert_hold_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && !s_gnt |=> s_req && $stable(s_aid[ID_W]));

  assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch && m0_req && m1_req && seen_launch |=> s_aid[ID_W] != $past(s_aid[ID_W]));

  assert_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && s_gnt |-> out_cnt < CNT_W'(MAX_OUT));

  assert_one_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(m0_rvalid && m1_rvalid));

  assert_hold_m0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m0_rvalid && !m0_rready |=> m0_rvalid && $stable(m0_rdata) && $stable(m0_rid));

  assert_hold_m1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m1_rvalid && !m1_rready |=> m1_rvalid && $stable(m1_rdata) && $stable(m1_rid));

  assert_gnt_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m0_gnt || m1_gnt) |-> s_req && s_gnt && !(m0_gnt && m1_gnt));

  assert_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && s_gnt |=> !s_req);

  assert_no_early_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_rready |-> out_cnt != '0);

  assert_addr_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && !s_gnt |=> $stable(s_addr) || !s_req);
endmodule

bind reqgnt_mux2 mux2_checker #(.ID_W(ID_W), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .m0_req    (m0_req),
  .m1_req    (m1_req),
  .m0_gnt    (m0_gnt),
  .m1_gnt    (m1_gnt),
  .m0_rvalid (m0_rvalid),
  .m1_rvalid (m1_rvalid),
  .m0_rready (m0_rready),
  .m1_rready (m1_rready),
  .m0_rdata  (m0_rdata),
  .m1_rdata  (m1_rdata),
  .m0_rid    (m0_rid),
  .m1_rid    (m1_rid),
  .s_req     (s_req),
  .s_gnt     (s_gnt),
  .s_addr    (s_addr),
  .s_aid     (s_aid),
  .s_rready  (s_rready),
  .launch    (launch),
  .out_cnt   (out_cnt)
);

// File: tb/reqgnt_mux2_tb.sv
`timescale 1ns/1ps
module reqgnt_mux2_tb;
  localparam int ID_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m0_req = 0, m0_we = 0, m0_rready = 0;
  logic [31:0] m0_addr = '0, m0_wdata = '0;
  logic [3:0] m0_be = '0;
  logic [ID_W-1:0] m0_aid = '0;
  logic m0_gnt, m0_rvalid, m0_err;
  logic [31:0] m0_rdata;
  logic [ID_W-1:0] m0_rid;

  logic m1_req = 0, m1_we = 0, m1_rready = 0;
  logic [31:0] m1_addr = '0, m1_wdata = '0;
  logic [3:0] m1_be = '0;
  logic [ID_W-1:0] m1_aid = '0;
  logic m1_gnt, m1_rvalid, m1_err;
  logic [31:0] m1_rdata;
  logic [ID_W-1:0] m1_rid;

  logic s_req, s_we, s_rready;
  logic [31:0] s_addr, s_wdata;
  logic [3:0] s_be;
  logic [ID_W:0] s_aid;
  logic s_gnt = 0, s_rvalid = 0, s_err = 0;
  logic [31:0] s_rdata = '0;
  logic [ID_W:0] s_rid = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  reqgnt_mux2 #(.ID_W(ID_W), .MAX_OUT(4)) u_dut (.*);

  task automatic eq(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    step(2);
    #1;
    eq(s_req, 0, "R1 s_req");
    eq(m0_rvalid, 0, "R1 m0_rvalid");
    eq(m1_rvalid, 0, "R1 m1_rvalid");
    eq(m0_gnt | m1_gnt, 0, "R1 gnt");
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_single;
    m1_req = 1; m1_addr = 32'h1000_0040; m1_we = 1; m1_be = 4'hC;
    m1_wdata = 32'hCAFE_0001; m1_aid = 2'd2; s_gnt = 0;
    #1;
    eq(s_req, 0, "R2 idle decision cycle");
    step();
    #1;
    eq(s_req, 1, "R2 s_req");
    eq(s_addr, 32'h1000_0040, "R2 s_addr");
    eq(s_aid, 3'b110, "R2 s_aid widened");
    eq(s_be, 4'hC, "R2 s_be");
    eq(s_wdata, 32'hCAFE_0001, "R2 s_wdata");
    eq(m1_gnt, 0, "R9 no gnt without s_gnt");
    step();
    #1;
    eq(s_req, 1, "R3 s_req held");
    eq(s_aid, 3'b110, "R3 selection held");
    s_gnt = 1;
    #1;
    eq(m1_gnt, 1, "R9 m1_gnt");
    eq(m0_gnt, 0, "R9 m0_gnt");
    step();
    m1_req = 0; s_gnt = 0;
    #1;
    eq(s_req, 0, "R10 gap");
    // response with a master that is not yet ready
    s_rvalid = 1; s_rid = 3'b110; s_rdata = 32'h5A5A_1234; s_err = 1;
    #1;
    eq(s_rready, 1, "R7 stage empty");
    step();
    s_rvalid = 0; s_err = 0;
    #1;
    eq(m1_rvalid, 1, "R6 m1_rvalid");
    eq(m1_rid, 2'd2, "R6 rid stripped");
    eq(m1_rdata, 32'h5A5A_1234, "R6 rdata");
    eq(m1_err, 1, "R6 err");
    eq(m0_rvalid, 0, "R6 m0 quiet");
    step();
    #1;
    eq(m1_rvalid, 1, "R8 held");
    eq(m1_rdata, 32'h5A5A_1234, "R8 data held");
    m1_rready = 1;
    step();
    #1;
    eq(m1_rvalid, 0, "R8 released");
    m1_rready = 0;
  endtask

  task automatic t_no_early;
    s_rvalid = 1; s_rid = 3'b000; s_rdata = 32'hDEAD_0000;
    #1;
    eq(s_rready, 0, "R11 s_rready");
    step();
    #1;
    eq(m0_rvalid | m1_rvalid, 0, "R11 no rvalid");
    s_rvalid = 0;
  endtask

  task automatic respond(input logic port, input logic [ID_W-1:0] id, input logic [31:0] data);
    m0_rready = 1; m1_rready = 1;
    s_rvalid = 1; s_rid = {port, id}; s_rdata = data;
    #1;
    eq(s_rready, 1, "R7 ready");
    step();
    s_rvalid = 0;
    #1;
    eq(port ? m1_rvalid : m0_rvalid, 1, "R6 routed");
    eq(port ? m0_rvalid : m1_rvalid, 0, "R6 other quiet");
    eq(port ? m1_rdata : m0_rdata, data, "R6 data");
    step();
    m0_rready = 0; m1_rready = 0;
  endtask

  task automatic t_round_robin;
    s_gnt = 1;
    m0_req = 1; m0_addr = 32'h2000_0000; m0_aid = 2'd1;
    m1_req = 1; m1_addr = 32'h3000_0000; m1_aid = 2'd3;
    step();
    #1;
    eq(s_aid, 3'b001, "R4 master0 first");
    eq(m0_gnt, 1, "R4 m0_gnt");
    step();
    m0_req = 0;
    #1;
    eq(s_req, 0, "R10 gap after m0");
    step();
    #1;
    eq(s_aid, 3'b111, "R4 master1 next");
    eq(s_addr, 32'h3000_0000, "R4 s_addr");
    step();
    m0_req = 1;
    step();
    #1;
    eq(s_aid[ID_W], 0, "R4 back to master0");
    step();
    m0_req = 0; m1_req = 0; s_gnt = 0;
    respond(1'b0, 2'd1, 32'h0000_0A01);
    respond(1'b1, 2'd3, 32'h0000_0B03);
    respond(1'b0, 2'd1, 32'h0000_0A02);
  endtask

  task automatic t_limit;
    int n = 0;
    s_gnt = 1; m0_req = 1; m0_aid = 2'd0;
    for (int i = 0; i < 10; i++) begin
      step();
      #1;
      if (s_req && s_gnt) n++;
    end
    eq(n, 4, "R5 accepted count");
    eq(s_req, 0, "R5 stalled");
    m0_rready = 0;
    s_rvalid = 1; s_rid = 3'b000; s_rdata = 32'h0000_0001;
    step();
    s_rdata = 32'h0000_0002;
    #1;
    eq(m0_rvalid, 1, "R7 next-cycle delivery");
    eq(s_rready, 0, "R7 stage full");
    step();
    m0_req = 0;
    #1;
    eq(s_req, 1, "R5 reopened");
    m0_rready = 1;
    #1;
    eq(s_rready, 1, "R7 drain ready");
    for (int i = 0; i < 3; i++) begin
      step();
      #1;
      eq(s_rready, 1, "R7 back-to-back");
    end
    step();
    #1;
    eq(s_rready, 0, "R11 drained");
    s_rvalid = 0; s_gnt = 0;
    step(2);
    m0_rready = 0;
  endtask

  initial begin
    #(5ns * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_no_early();
    t_round_robin();
    t_limit();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule